// File: doc/BRIEF.md
# Transmit Queue Occupancy Tracker with Clear-to-Send Start Gating

This block does the occupancy bookkeeping for the transmit queue of one serial channel. The host side pulses a push strobe for every character it places in the 64-entry queue. The serializer pulses a pop strobe for every character it takes out. The block keeps an 8-bit count of the characters held, and software can read that count directly. The count is compared against a trigger level that software programs. A low-water interrupt stays raised while the occupancy is below that trigger level, so software knows when to refill the queue.

The block also decides whether the serializer may begin a new character. With automatic flow control turned off, a start is permitted whenever the queue holds data. With it turned on, one of two active-low modem inputs is chosen by a select bit: the clear-to-send line or the data-set-ready line. The chosen input is passed through a synchronizer. While that input is high, new starts are held off. A character that is already being shifted out is not affected, because the permit only qualifies the start of the next character.

Top module: `txl_tx_level`

## Requirements
- R1: In the cycle after synchronous reset is applied, the level reads 0, the interrupt is low, the stored trigger level is 0, and the synchronized modem inputs read high (blocking).
- R2: A push alone increments the level by one and a pop alone decrements it by one, each visible in the cycle after the strobe; the level never exceeds 64.
- R3: A push alone while the level is 64 is ignored and the level stays 64.
- R4: A pop alone while the level is 0 is ignored and the level stays 0.
- R5: A push and a pop in the same cycle leave the level unchanged, whatever its value.
- R6: A trigger write stores the 8-bit value in the cycle after the strobe; values from 0 to 64 are stored as given and any value above 64 is stored as 64.
- R7: The interrupt is high exactly while the current level is strictly below the stored trigger level.
- R8: The start permit is low whenever the level is 0.
- R9: With the auto-flow enable low, the start permit equals "level not zero" regardless of both modem inputs.
- R10: With the auto-flow enable high, the select bit chooses the gating input (0 = clear-to-send, 1 = data-set-ready). A high level on that input blocks the permit and a low level allows it. Each input reaches the gate through a two-stage synchronizer, so an input change affects the permit after the second rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Host placed one character in the queue |
| pop_i | input | 1 | Serializer took one character from the queue |
| trig_wr_i | input | 1 | Write strobe for the trigger level |
| trig_data_i | input | 8 | Trigger level value to store |
| auto_flow_en_i | input | 1 | Enables modem-line start gating |
| flow_sel_i | input | 1 | 0 selects clear-to-send, 1 selects data-set-ready |
| cts_n_i | input | 1 | Active-low clear-to-send line, asynchronous |
| dsr_n_i | input | 1 | Active-low data-set-ready line, asynchronous |
| level_o | output | 8 | Current queue occupancy, 0 to 64 |
| low_water_irq_o | output | 1 | High while the level is below the trigger level |
| tx_permit_o | output | 1 | Serializer may begin the next character |

## Verification
The bench uses the default parameters: a depth of 64 and two synchronizer stages. At that depth both saturation boundaries can be reached in under a hundred strobes, and a trigger write above 64 shows the clamp. With two stages, the two-edge delay from a modem line to the permit is checked exactly on every clock, because the reference model delays each line by two samples. A long random phase then mixes strobes, trigger writes, select changes and line toggles, so that the interrupt and the permit are compared at many level and trigger combinations.

// File: rtl/txl_pkg.sv
package txl_pkg;

    localparam int LVL_W = 8;

    typedef enum logic {
        SRC_CTS = 1'b0,
        SRC_DSR = 1'b1
    } flow_src_e;

    typedef struct packed {
        logic push;
        logic pop;
    } fifo_evt_t;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_INC  = 2'd1,
        OP_DEC  = 2'd2
    } lvl_op_e;

    function automatic lvl_op_e decode_op(fifo_evt_t ev, logic full, logic empty);
        lvl_op_e op;
        op = OP_HOLD;
        if (ev.push && !ev.pop && !full)
            op = OP_INC;
        else if (ev.pop && !ev.push && !empty)
            op = OP_DEC;
        return op;
    endfunction

    function automatic logic [LVL_W-1:0] clamp_level(logic [LVL_W-1:0] v,
                                                     logic [LVL_W-1:0] cap);
        return (v > cap) ? cap : v;
    endfunction

endpackage

// File: rtl/txl_level_counter.sv
module txl_level_counter
    import txl_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  fifo_evt_t        evt_i,
    output logic [LVL_W-1:0] level_o,
    output logic             empty_o
);
    localparam logic [LVL_W-1:0] FULL_V = LVL_W'(DEPTH);

    logic [LVL_W-1:0] level_q;
    logic             full;
    lvl_op_e          op;

    assign full    = (level_q == FULL_V);
    assign empty_o = (level_q == '0);
    assign op      = decode_op(evt_i, full, empty_o);

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
        end else begin
            unique case (op)
                OP_INC:  level_q <= level_q + LVL_W'(1);
                OP_DEC:  level_q <= level_q - LVL_W'(1);
                default: level_q <= level_q;
            endcase
        end
    end

    assign level_o = level_q;

    a_r2_level_bound: assert property (@(posedge clk) disable iff (rst)
        level_q <= FULL_V);

    a_r2_single_push_step: assert property (@(posedge clk) disable iff (rst)
        (evt_i.push && !evt_i.pop && level_q < FULL_V) |=> level_q == $past(level_q) + LVL_W'(1));

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (evt_i.push && !evt_i.pop && level_q == FULL_V) |=> level_q == FULL_V);

    a_r4_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (evt_i.pop && !evt_i.push && level_q == '0) |=> level_q == '0);

    a_r5_paired_hold: assert property (@(posedge clk) disable iff (rst)
        (evt_i.push && evt_i.pop) |=> $stable(level_q));

endmodule

// File: rtl/txl_trigger_reg.sv
module txl_trigger_reg
    import txl_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  logic [LVL_W-1:0] data_i,
    output logic [LVL_W-1:0] trig_o
);
    localparam logic [LVL_W-1:0] CAP_V = LVL_W'(DEPTH);

    logic [LVL_W-1:0] trig_q;

    always_ff @(posedge clk) begin
        if (rst)
            trig_q <= '0;
        else if (wr_i)
            trig_q <= clamp_level(data_i, CAP_V);
    end

    assign trig_o = trig_q;

    a_r6_trig_bound: assert property (@(posedge clk) disable iff (rst)
        trig_q <= CAP_V);

    a_r6_trig_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> $stable(trig_q));

endmodule

// File: rtl/txl_sync_chain.sv
module txl_sync_chain #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES:0] chain;

    assign chain[0] = d_i;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                chain[i+1] <= RESET_VAL;
            else
                chain[i+1] <= chain[i];
        end
    end

    assign q_o = chain[STAGES];

endmodule

// File: rtl/txl_flow_gate.sv
module txl_flow_gate
    import txl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en_i,
    input  flow_src_e sel_i,
    input  logic      cts_n_i,
    input  logic      dsr_n_i,
    input  logic      has_data_i,
    output logic      permit_o
);
    logic cts_n_s;
    logic dsr_n_s;
    logic line_n;
    logic blocked;

    txl_sync_chain #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_cts_sync (
        .clk (clk),
        .rst (rst),
        .d_i (cts_n_i),
        .q_o (cts_n_s)
    );

    txl_sync_chain #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_dsr_sync (
        .clk (clk),
        .rst (rst),
        .d_i (dsr_n_i),
        .q_o (dsr_n_s)
    );

    always_comb begin
        unique case (sel_i)
            SRC_DSR: line_n = dsr_n_s;
            default: line_n = cts_n_s;
        endcase
    end

    assign blocked  = en_i && line_n;
    assign permit_o = has_data_i && !blocked;

endmodule

// File: rtl/txl_tx_level.sv
module txl_tx_level
    import txl_pkg::*;
#(
    parameter int DEPTH       = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push_i,
    input  logic       pop_i,
    input  logic       trig_wr_i,
    input  logic [7:0] trig_data_i,
    input  logic       auto_flow_en_i,
    input  logic       flow_sel_i,
    input  logic       cts_n_i,
    input  logic       dsr_n_i,
    output logic [7:0] level_o,
    output logic       low_water_irq_o,
    output logic       tx_permit_o
);
    fifo_evt_t        evt;
    logic [LVL_W-1:0] level;
    logic [LVL_W-1:0] trig;
    logic             empty;
    flow_src_e        src;

    assign evt.push = push_i;
    assign evt.pop  = pop_i;
    assign src      = flow_src_e'(flow_sel_i);

    txl_level_counter #(.DEPTH(DEPTH)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .evt_i   (evt),
        .level_o (level),
        .empty_o (empty)
    );

    txl_trigger_reg #(.DEPTH(DEPTH)) u_trigger (
        .clk    (clk),
        .rst    (rst),
        .wr_i   (trig_wr_i),
        .data_i (trig_data_i),
        .trig_o (trig)
    );

    txl_flow_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
        .clk        (clk),
        .rst        (rst),
        .en_i       (auto_flow_en_i),
        .sel_i      (src),
        .cts_n_i    (cts_n_i),
        .dsr_n_i    (dsr_n_i),
        .has_data_i (!empty),
        .permit_o   (tx_permit_o)
    );

    assign level_o         = level;
    assign low_water_irq_o = (level < trig);

    a_r8_no_permit_when_empty: assert property (@(posedge clk) disable iff (rst)
        (level_o == 8'd0) |-> !tx_permit_o);

    a_r7_full_queue_quiet: assert property (@(posedge clk) disable iff (rst)
        (level_o == 8'(DEPTH)) |-> !low_water_irq_o);

endmodule

// File: tb/txl_tx_level_bench.sv
module txl_tx_level_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       push_i, pop_i, trig_wr_i;
    logic [7:0] trig_data_i;
    logic       auto_flow_en_i, flow_sel_i, cts_n_i, dsr_n_i;
    logic [7:0] level_o;
    logic       low_water_irq_o, tx_permit_o;

    txl_tx_level u_txl_tx_level (
        .clk             (clk),
        .rst             (rst),
        .push_i          (push_i),
        .pop_i           (pop_i),
        .trig_wr_i       (trig_wr_i),
        .trig_data_i     (trig_data_i),
        .auto_flow_en_i  (auto_flow_en_i),
        .flow_sel_i      (flow_sel_i),
        .cts_n_i         (cts_n_i),
        .dsr_n_i         (dsr_n_i),
        .level_o         (level_o),
        .low_water_irq_o (low_water_irq_o),
        .tx_permit_o     (tx_permit_o)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    string lvl_tag = "R1";
    string prm_tag = "R1";

    // staged inputs, applied at the falling edge after checks
    logic       n_rst = 1'b1, n_push = 1'b0, n_pop = 1'b0, n_wr = 1'b0;
    logic [7:0] n_data = 8'd0;
    logic       n_en = 1'b0, n_sel = 1'b0, n_cts = 1'b1, n_dsr = 1'b1;

    // behavioural reference model
    int m_level = 0;
    int m_trig  = 0;
    int cts_hist[2] = '{1, 1};
    int dsr_hist[2] = '{1, 1};

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_level = 0;
            m_trig  = 0;
            cts_hist = '{1, 1};
            dsr_hist = '{1, 1};
        end else begin
            if (push_i && !pop_i && m_level < 64) m_level++;
            else if (pop_i && !push_i && m_level > 0) m_level--;
            if (trig_wr_i) m_trig = (int'(trig_data_i) > 64) ? 64 : int'(trig_data_i);
            cts_hist[1] = cts_hist[0];
            cts_hist[0] = int'(cts_n_i);
            dsr_hist[1] = dsr_hist[0];
            dsr_hist[0] = int'(dsr_n_i);
        end
    end

    task automatic chk(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cycles);
        end
    endtask

    task automatic check_all();
        int line;
        int exp_permit;
        line = flow_sel_i ? dsr_hist[1] : cts_hist[1];
        exp_permit = (m_level != 0 && (!auto_flow_en_i || line == 0)) ? 1 : 0;
        chk(lvl_tag, int'(level_o), m_level, "level");
        chk("R7", int'(low_water_irq_o), (m_level < m_trig) ? 1 : 0, "irq");
        chk(prm_tag, int'(tx_permit_o), exp_permit, "permit");
    endtask

    task automatic tick();
        @(negedge clk);
        check_all();
        rst = n_rst; push_i = n_push; pop_i = n_pop; trig_wr_i = n_wr;
        trig_data_i = n_data; auto_flow_en_i = n_en; flow_sel_i = n_sel;
        cts_n_i = n_cts; dsr_n_i = n_dsr;
    endtask

    task automatic strobe(input logic p, input logic q, input int n);
        n_push = p; n_pop = q;
        for (int i = 0; i < n; i++) tick();
        n_push = 1'b0; n_pop = 1'b0;
    endtask

    task automatic write_trig(input int v);
        n_wr = 1'b1; n_data = 8'(v);
        tick();
        n_wr = 1'b0;
        tick();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected<=150000", cycles);
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; push_i = 0; pop_i = 0; trig_wr_i = 0; trig_data_i = 0;
        auto_flow_en_i = 0; flow_sel_i = 0; cts_n_i = 1; dsr_n_i = 1;
        repeat (3) @(posedge clk);
        // R1: reset state
        lvl_tag = "R1"; prm_tag = "R1";
        tick(); tick();
        n_rst = 1'b0;
        tick(); tick();

        // R2 fill, R3 saturation at 64
        lvl_tag = "R2"; prm_tag = "R8";
        strobe(1, 0, 64);
        lvl_tag = "R3";
        strobe(1, 0, 6);
        // R5 at full
        lvl_tag = "R5";
        strobe(1, 1, 4);

        // R6 clamp above 64, then R7 low-water as the queue drains
        lvl_tag = "R6";
        write_trig(200);
        write_trig(64);
        write_trig(10);
        lvl_tag = "R2";
        strobe(0, 1, 60);
        lvl_tag = "R5";
        strobe(1, 1, 3);
        // R4 underflow ignored, R8 permit low when empty
        lvl_tag = "R4"; prm_tag = "R8";
        strobe(0, 1, 8);
        lvl_tag = "R5";
        strobe(1, 1, 3);
        write_trig(0);
        write_trig(64);

        // R9: flow disabled, lines ignored
        lvl_tag = "R2"; prm_tag = "R9";
        strobe(1, 0, 5);
        n_en = 0;
        for (int i = 0; i < 8; i++) begin
            n_cts = i[0]; n_dsr = i[1]; n_sel = i[2];
            tick(); tick(); tick();
        end

        // R10: flow enabled, select and synchronizer latency
        prm_tag = "R10";
        n_en = 1; n_sel = 0; n_cts = 1; n_dsr = 0;
        repeat (4) tick();
        n_cts = 0; repeat (4) tick();
        n_cts = 1; repeat (4) tick();
        n_sel = 1; repeat (4) tick();
        n_dsr = 1; repeat (4) tick();
        n_dsr = 0; n_cts = 0; repeat (4) tick();
        n_sel = 0; repeat (4) tick();
        for (int i = 0; i < 12; i++) begin
            n_cts = ~n_cts; tick();
        end

        // mixed random traffic
        lvl_tag = "R2"; prm_tag = "R10";
        for (int i = 0; i < 4000; i++) begin
            n_push = ($urandom_range(0, 99) < 55);
            n_pop  = ($urandom_range(0, 99) < 45);
            n_wr   = ($urandom_range(0, 99) < 5);
            n_data = 8'($urandom_range(0, 90));
            if ($urandom_range(0, 99) < 10) n_en  = ~n_en;
            if ($urandom_range(0, 99) < 10) n_sel = ~n_sel;
            if ($urandom_range(0, 99) < 20) n_cts = ~n_cts;
            if ($urandom_range(0, 99) < 20) n_dsr = ~n_dsr;
            tick();
        end
        n_push = 0; n_pop = 0; n_wr = 0;
        tick(); tick();
        finish_run();
    end

endmodule